// File: doc/BRIEF.md
# Stereo 64-to-1 Decimation Chain

This block takes a stereo stream of signed multi-bit samples arriving at sixty-four times the audio sample rate and returns one stereo pair of 24-bit samples per sixty-four accepted inputs. Rate reduction happens in two steps. A fourth-order comb-integrator filter first divides the rate by eight. Three half-band FIR stages in cascade then each halve the rate.

Each input pair is accepted on a cycle where `in_valid` is high. Input data on other cycles has no effect. The half-band stages use one multiplier per stage, which serves the left and right channels in turn. Their coefficients are built-in constants. Each output pair appears together with a single-cycle `out_valid` pulse, and the outputs hold their value between pulses.

Top module: `audio_decim_chain`

## Requirements
- R1: Once primed, exactly one output pair is produced for every 64 accepted input pairs. The k-th output pair (counting from 0) never appears before 344 + 64·k input pairs have been accepted.
- R2: The first stage behaves as a 4th-order comb filter that decimates by 8 and has a DC gain of 4096. Its m-th output is the exact sum of h[k]·x[8m+7−k], where h holds the coefficients of (1+z⁻¹+…+z⁻⁷)⁴. Inputs from before reset count as zero. The stage output is DIN_W+12 bits wide.
- R3: Each half-band stage takes inputs s[j] and forms y = (16·s[j−3] + 9·(s[j−2]+s[j−4]) − (s[j]+s[j−6]) + 16) >> 5, using an arithmetic shift. The result is saturated to DIN_W+12 bits.
- R4: The final 26-bit value v (at the default DIN_W=14) becomes the output (v+2) >> 2, using an arithmetic shift and saturated to the signed 24-bit range.
- R5: A half-band stage produces its first output on its 7th input (j=6). After that it produces one output on every second input (j=8, 10, …). As a result, the first chain output needs 344 accepted inputs.
- R6: `out_valid` is a single-cycle pulse that never stays high for two consecutive cycles. Left and right outputs update together on that pulse and hold their value otherwise.
- R7: A synchronous active-high reset clears every delay line. After reset, `out_valid` is 0, both outputs are 0, and the next stream is filtered as if all earlier input were zero.
- R8: Input data on cycles with `in_valid` low is ignored.
- R9: `in_valid` may be high on every cycle.
- R10: The left and right channels are filtered independently, with no crosstalk, even though they share a multiplier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair strobe |
| in_l | input | DIN_W | Left input sample, signed |
| in_r | input | DIN_W | Right input sample, signed |
| out_valid | output | 1 | Output pair strobe |
| out_l | output | OUT_W | Left output sample, signed |
| out_r | output | OUT_W | Right output sample, signed |

## Verification
The hardest condition to reach is saturation inside a half-band stage. It occurs only when the comb output is already at full scale and a step drives the negative outer taps beyond range. The stimulus therefore holds both channels at opposite full-scale values and then swaps them. This produces a large step in each direction, and the overshoot clips in both directions. Gaps of random length in `in_valid`, with garbage data on the idle cycles, exercise rate control and the rule that idle inputs are ignored. A reset between two runs confirms that no history carries over.

// File: rtl/decim_pkg.sv
package decim_pkg;
    localparam int CIC_ORDER  = 4;
    localparam int CIC_RATE   = 8;
    localparam int CIC_GROWTH = CIC_ORDER * $clog2(CIC_RATE);
    localparam int HB_STAGES  = 3;
    localparam int HB_TAPS    = 7;
    localparam int HB_NPAIR   = 2;
    localparam int HB_SHIFT   = 5;
    // Outer-to-inner nonzero side taps; centre tap is 2^(HB_SHIFT-1)
    localparam int HB_COEF [HB_NPAIR] = '{-1, 9};

    typedef enum logic {CH_L = 1'b0, CH_R = 1'b1} chan_e;

    function automatic longint clip(input longint v, input int w);
        longint hi, lo;
        hi = (64'sd1 <<< (w - 1)) - 64'sd1;
        lo = -hi - 64'sd1;
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction
endpackage

// File: rtl/decim_cic4.sv
module decim_cic4
    import decim_pkg::*;
#(
    parameter int DIN_W = 14,
    parameter int W     = DIN_W + CIC_GROWTH
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [DIN_W-1:0] in_l,
    input  logic signed [DIN_W-1:0] in_r,
    output logic                    out_valid,
    output logic signed [W-1:0]     out_l,
    output logic signed [W-1:0]     out_r
);
    localparam int ORD   = CIC_ORDER;
    localparam int CNT_W = $clog2(CIC_RATE);

    logic [CNT_W-1:0] ph;
    logic             wrap;
    logic signed [W-1:0] xin [2];

    assign wrap   = (ph == CNT_W'(CIC_RATE - 1));
    assign xin[0] = W'(in_l);
    assign xin[1] = W'(in_r);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid && wrap;
            if (in_valid) ph <= ph + 1'b1;
        end
    end

    for (genvar c = 0; c < 2; c++) begin : g_ch
        logic signed [W-1:0] integ [ORD];
        logic signed [W-1:0] inxt  [ORD];
        logic signed [W-1:0] dly   [ORD];
        logic signed [W-1:0] diff  [ORD];
        logic signed [W-1:0] yreg;

        always_comb begin
            logic signed [W-1:0] run;
            run = xin[c];
            for (int k = 0; k < ORD; k++) begin
                run     = integ[k] + run;
                inxt[k] = run;
            end
            run = inxt[ORD-1];
            for (int k = 0; k < ORD; k++) begin
                run     = run - dly[k];
                diff[k] = run;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int k = 0; k < ORD; k++) begin
                    integ[k] <= '0;
                    dly[k]   <= '0;
                end
                yreg <= '0;
            end else if (in_valid) begin
                for (int k = 0; k < ORD; k++) integ[k] <= inxt[k];
                if (wrap) begin
                    dly[0] <= inxt[ORD-1];
                    for (int k = 1; k < ORD; k++) dly[k] <= diff[k-1];
                    yreg <= diff[ORD-1];
                end
            end
        end
    end

    assign out_l = g_ch[0].yreg;
    assign out_r = g_ch[1].yreg;
endmodule

// File: rtl/decim_halfband.sv
module decim_halfband
    import decim_pkg::*;
#(
    parameter int W = 26
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_l,
    input  logic signed [W-1:0] in_r,
    output logic                out_valid,
    output logic signed [W-1:0] out_l,
    output logic signed [W-1:0] out_r
);
    localparam int NT   = HB_TAPS;
    localparam int CTR  = (NT - 1) / 2;
    localparam int NOPS = 2 * HB_NPAIR;
    localparam int OPW  = $clog2(NOPS);
    localparam int FW   = $clog2(NT + 1);
    localparam int IW   = $clog2(NT);
    localparam int AW   = W + 8;
    localparam logic signed [AW-1:0] HALF = AW'(1 <<< (HB_SHIFT - 1));

    logic signed [W-1:0]  tl [NT];
    logic signed [W-1:0]  tr [NT];
    logic [FW-1:0]        fill;
    logic                 phase, busy, fin;
    logic [OPW-1:0]       op;
    logic signed [AW-1:0] acc_l, acc_r, prod;
    logic signed [W:0]    psum;
    logic signed [W-1:0]  ta, tb, rl, rr;
    logic [IW-1:0]        ia, ib;
    chan_e                ch;
    int                   pidx;

    // One shared multiplier: op walks left pairs, then right pairs
    always_comb begin
        pidx = int'(op) % HB_NPAIR;
        ch   = (int'(op) >= HB_NPAIR) ? CH_R : CH_L;
        ia   = IW'(2 * pidx);
        ib   = IW'(NT - 1 - 2 * pidx);
        ta   = (ch == CH_R) ? tr[ia] : tl[ia];
        tb   = (ch == CH_R) ? tr[ib] : tl[ib];
        psum = (W+1)'(ta) + (W+1)'(tb);
        prod = AW'(psum) * AW'(HB_COEF[pidx]);
        rl   = W'(clip(longint'((acc_l + HALF) >>> HB_SHIFT), W));
        rr   = W'(clip(longint'((acc_r + HALF) >>> HB_SHIFT), W));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NT; k++) begin
                tl[k] <= '0;
                tr[k] <= '0;
            end
            fill      <= '0;
            phase     <= 1'b0;
            busy      <= 1'b0;
            fin       <= 1'b0;
            op        <= '0;
            acc_l     <= '0;
            acc_r     <= '0;
            out_valid <= 1'b0;
            out_l     <= '0;
            out_r     <= '0;
        end else begin
            out_valid <= 1'b0;
            fin       <= 1'b0;
            if (in_valid) begin
                tl[0] <= in_l;
                tr[0] <= in_r;
                for (int k = 1; k < NT; k++) begin
                    tl[k] <= tl[k-1];
                    tr[k] <= tr[k-1];
                end
                if (fill < FW'(NT)) fill <= fill + 1'b1;
                phase <= ~phase;
                if (!phase && fill >= FW'(NT - 1)) begin
                    busy  <= 1'b1;
                    op    <= '0;
                    acc_l <= AW'(tl[CTR-1]) <<< (HB_SHIFT - 1);
                    acc_r <= AW'(tr[CTR-1]) <<< (HB_SHIFT - 1);
                end
            end else if (busy) begin
                if (ch == CH_L) acc_l <= acc_l + prod;
                else            acc_r <= acc_r + prod;
                op <= op + 1'b1;
                if (op == OPW'(NOPS - 1)) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
            if (fin) begin
                out_l     <= rl;
                out_r     <= rr;
                out_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/audio_decim_chain.sv
module audio_decim_chain
    import decim_pkg::*;
#(
    parameter int DIN_W = 14,
    parameter int OUT_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [DIN_W-1:0] in_l,
    input  logic signed [DIN_W-1:0] in_r,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_l,
    output logic signed [OUT_W-1:0] out_r
);
    localparam int W  = DIN_W + CIC_GROWTH;
    localparam int NS = HB_STAGES;
    localparam int SH = W - OUT_W;

    logic                sv [NS+1];
    logic signed [W-1:0] sl [NS+1];
    logic signed [W-1:0] sr [NS+1];
    logic signed [OUT_W-1:0] yl, yr;

    decim_cic4 #(.DIN_W(DIN_W), .W(W)) u_cic (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_l(in_l), .in_r(in_r),
        .out_valid(sv[0]), .out_l(sl[0]), .out_r(sr[0])
    );

    for (genvar s = 0; s < NS; s++) begin : g_hb
        decim_halfband #(.W(W)) u_hb (
            .clk(clk), .rst(rst), .in_valid(sv[s]),
            .in_l(sl[s]), .in_r(sr[s]),
            .out_valid(sv[s+1]), .out_l(sl[s+1]), .out_r(sr[s+1])
        );
    end

    if (SH > 0) begin : g_round
        always_comb begin
            yl = OUT_W'(clip((longint'(sl[NS]) + (64'sd1 <<< (SH - 1))) >>> SH, OUT_W));
            yr = OUT_W'(clip((longint'(sr[NS]) + (64'sd1 <<< (SH - 1))) >>> SH, OUT_W));
        end
    end else begin : g_widen
        always_comb begin
            yl = OUT_W'(longint'(sl[NS]) <<< (-SH));
            yr = OUT_W'(longint'(sr[NS]) <<< (-SH));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_l     <= '0;
            out_r     <= '0;
        end else begin
            out_valid <= sv[NS];
            if (sv[NS]) begin
                out_l <= yl;
                out_r <= yr;
            end
        end
    end
endmodule

// File: rtl/audio_decim_chain_chk.sv
module audio_decim_chain_chk
    import decim_pkg::*;
#(
    parameter int OUT_W = 24
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_l,
    input logic signed [OUT_W-1:0] out_r
);
    function automatic int prime_inputs();
        int idx;
        idx = HB_TAPS - 1;
        for (int s = 1; s < HB_STAGES; s++) idx = HB_TAPS - 1 + 2 * idx;
        return CIC_RATE * (idx + 1);
    endfunction

    localparam longint PRIME = longint'(prime_inputs());
    localparam longint DECIM = longint'(CIC_RATE << HB_STAGES);

    longint in_cnt, out_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_cnt  <= 0;
            out_cnt <= 0;
        end else begin
            if (in_valid)  in_cnt  <= in_cnt + 1;
            if (out_valid) out_cnt <= out_cnt + 1;
        end
    end

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_l) && $stable(out_r)));

    a_r5_prime: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (in_cnt >= PRIME));

    a_r1_ratio: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (in_cnt >= PRIME + DECIM * out_cnt));
endmodule

bind audio_decim_chain audio_decim_chain_chk #(.OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .out_valid(out_valid), .out_l(out_l), .out_r(out_r)
);

// File: tb/audio_decim_chain_bench.sv
`timescale 1ns/1ps
module audio_decim_chain_bench;
    localparam int DIN_W = 14;
    localparam int OUT_W = 24;
    localparam int W     = DIN_W + 12;
    localparam longint FSP = (64'sd1 <<< (DIN_W - 1)) - 1;
    localparam longint FSN = -(64'sd1 <<< (DIN_W - 1));

    logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
    logic signed [DIN_W-1:0] in_l = '0, in_r = '0;
    logic out_valid;
    logic signed [OUT_W-1:0] out_l, out_r;

    always #2.5 clk = ~clk;

    audio_decim_chain #(.DIN_W(DIN_W), .OUT_W(OUT_W)) u_audio_decim_chain (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
        .out_valid(out_valid), .out_l(out_l), .out_r(out_r)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    longint src_l[$], src_r[$], got_l[$], got_r[$], hk[$];
    int in_at_first = -1, dbl = 0;
    bit prev_v = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (got_l.size() == 0) in_at_first = src_l.size();
                got_l.push_back(longint'(out_l));
                got_r.push_back(longint'(out_r));
                if (prev_v) dbl++;
            end
            prev_v = out_valid;
        end else prev_v = 1'b0;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sat(input longint v, input int w);
        longint hi = (64'sd1 <<< (w - 1)) - 1;
        if (v > hi) return hi;
        if (v < -hi - 1) return -hi - 1;
        return v;
    endfunction

    // coefficients of (1 + z^-1 + ... + z^-7)^4
    function automatic void build_h();
        longint p[$], q[$];
        p.push_back(1);
        for (int o = 0; o < 4; o++) begin
            q.delete();
            for (int i = 0; i < p.size() + 7; i++) q.push_back(0);
            for (int i = 0; i < p.size(); i++)
                for (int k = 0; k < 8; k++) q[i+k] = q[i+k] + p[i];
            p = q;
        end
        hk = p;
    endfunction

    function automatic void ref_chain(input longint x[$], output longint y[$]);
        longint s[$], t[$], acc;
        int m;
        m = x.size() / 8;
        for (int i = 0; i < m; i++) begin
            acc = 0;
            for (int k = 0; k < hk.size(); k++)
                if (8*i + 7 - k >= 0) acc += hk[k] * x[8*i + 7 - k];
            s.push_back(acc);
        end
        for (int st = 0; st < 3; st++) begin
            t.delete();
            for (int j = 6; j < s.size(); j += 2) begin
                acc = 16*s[j-3] + 9*(s[j-2] + s[j-4]) - (s[j] + s[j-6]);
                t.push_back(sat((acc + 16) >>> 5, W));
            end
            s = t;
        end
        y.delete();
        for (int i = 0; i < s.size(); i++) y.push_back(sat((s[i] + 2) >>> 2, OUT_W));
    endfunction

    function automatic longint rnd_s();
        return longint'($urandom % (32'd1 << DIN_W)) + FSN;
    endfunction

    task automatic drive(input longint l, input longint r);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_l = DIN_W'(l);
        in_r = DIN_W'(r);
        src_l.push_back(l);
        src_r.push_back(r);
    endtask

    // R8: garbage on idle cycles
    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
            in_l = DIN_W'($urandom);
            in_r = DIN_W'($urandom);
        end
    endtask

    task automatic start_run();
        @(posedge clk); #1;
        rst = 1'b1; in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        src_l.delete(); src_r.delete(); got_l.delete(); got_r.delete();
        in_at_first = -1; dbl = 0;
        @(negedge clk);
        check(out_valid == 1'b0, "R7 reset valid", longint'(out_valid), 0);
        check(out_l == '0 && out_r == '0, "R7 reset data", longint'(out_l), 0);
    endtask

    task automatic finish_run(input string tag);
        longint el[$], er[$];
        int n;
        idle(400);
        ref_chain(src_l, el);
        ref_chain(src_r, er);
        $display("%s: %0d inputs, %0d outputs", tag, src_l.size(), got_l.size());
        check(got_l.size() == el.size(), "R1 R5 output count", got_l.size(), el.size());
        check(in_at_first >= 344, "R5 priming", in_at_first, 344);
        check(dbl == 0, "R6 single pulse", dbl, 0);
        n = (got_l.size() < el.size()) ? got_l.size() : el.size();
        for (int i = 0; i < n; i++) begin
            check(got_l[i] == el[i], "R2 R3 R4 left", got_l[i], el[i]);
            check(got_r[i] == er[i], "R10 R3 R4 right", got_r[i], er[i]);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        void'($urandom(32'h1D5E));
        build_h();
        start_run();
        // R9: back-to-back valid; opposite full-scale steps force saturation
        for (int k = 0; k < 400; k++) drive(FSP, FSN);
        for (int k = 0; k < 400; k++) drive(FSN, FSP);
        for (int k = 0; k < 400; k++) drive((k % 2) ? FSP : FSN, (k % 2) ? FSN : FSP);
        for (int k = 0; k < 1600; k++) drive(rnd_s(), rnd_s());
        finish_run("run1 R9");
        // R7 reset after nonzero history, R8 random gaps with garbage
        start_run();
        for (int k = 0; k < 2400; k++) begin
            if ($urandom % 2 == 0) idle(1 + int'($urandom % 3));
            drive(rnd_s(), rnd_s());
        end
        finish_run("run2 R7 R8");
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule